// File: doc/BRIEF.md
# Vector Operand Relative Index Remapper

This block sits in the operand-decode stage of a vector processor. It adds a shared register offset to chosen operand slots of a vector instruction. Two configuration registers are loaded through a small write port:

- The mode register holds an enable flag.
- The index register holds the offset and a four-bit slot mask.

Each instruction brings three source operand codes, one destination operand code and the number of vector registers allocated to the issuing wave.

For every slot whose mask bit is set while indexing is enabled, the block adds the offset to the vector register number. The result is kept only if it names a register the wave owns. Otherwise the slot is forced to vector register zero. If the selected operand is not a vector register at all, it is also forced to vector register zero. Slots that are not selected, and all slots while indexing is off, pass through untouched. Results leave one cycle later, together with a delayed valid flag.

Top module: `vreg_offset_remap`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) drives `out_valid` low on the following cycle. It also clears the enable flag, the offset and the slot mask, so every operand passes through after reset.
- R2: Outputs are registered with one cycle of latency. `out_valid` equals `in_valid` from the previous cycle, and the results belong to the instruction presented on that cycle.
- R3: Writing with `cfg_sel` = 0 loads the mode register, and its bit 27 is the enable flag. While the flag is clear, all four outputs equal their inputs.
- R4: Writing with `cfg_sel` = 1 loads the index register, and bits 7:0 form the offset. For a selected slot holding code 256+n, the output is 256+(n+offset) when n+offset is below `in_vcount`.
- R5: Index register bits 15:12 form the slot mask: bit 12 selects source 0, bit 13 source 1, bit 14 source 2 and bit 15 the destination. A slot whose mask bit is clear passes through unchanged even with indexing enabled.
- R6: If n+offset is greater than or equal to `in_vcount` (1 to 256), the selected slot outputs code 256 (vector register 0). No wrap-around occurs, including for the largest sum, 255+255.
- R7: A selected slot whose input code is below 256 (a non-vector operand) outputs code 256.
- R8: A configuration write takes effect for instructions presented on the next cycle. An instruction on the same cycle as the write uses the old values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 = mode, 1 = index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Instruction operands valid |
| in_src0 | input | 9 | Source operand 0 code |
| in_src1 | input | 9 | Source operand 1 code |
| in_src2 | input | 9 | Source operand 2 code |
| in_dst | input | 9 | Destination operand code |
| in_vcount | input | 9 | Vector registers allocated to the wave (1..256) |
| out_valid | output | 1 | Remapped operands valid |
| out_src0 | output | 9 | Remapped source 0 code |
| out_src1 | output | 9 | Remapped source 1 code |
| out_src2 | output | 9 | Remapped source 2 code |
| out_dst | output | 9 | Remapped destination code |

## Verification
Two events can land on the same cycle: a configuration write and an instruction that reads the configuration. The bench provokes this by asserting the write strobe and the instruction valid on one cycle, changing the offset, slot mask or enable flag. It then sends a second instruction on the next cycle. The scoreboard expects the first result to be computed from the old register values and the second from the new ones. Inside a single instruction, one cycle can also combine out-of-range fallback, non-vector fallback, in-range addition and pass-through on different slots. Each slot is then compared on its own.

// File: rtl/vreg_remap_pkg.sv
package vreg_remap_pkg;

   // operand slot order; the mask bit of slot k sits at MASK_LSB + k
   localparam int SLOT_SRC0 = 0;
   localparam int SLOT_SRC1 = 1;
   localparam int SLOT_SRC2 = 2;
   localparam int SLOT_DST  = 3;
   localparam int NUM_SLOTS = 4;

   typedef enum logic {
      CFG_MODE  = 1'b0,
      CFG_INDEX = 1'b1
   } cfg_sel_e;

endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs #(
   parameter int CFG_W    = 32,
   parameter int EN_BIT   = 27,
   parameter int OFS_W    = 8,
   parameter int MASK_LSB = 12,
   parameter int SLOTS    = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [CFG_W-1:0] wr_data,
   output logic             en_q,
   output logic [OFS_W-1:0] ofs_q,
   output logic [SLOTS-1:0] mask_q
);
   import vreg_remap_pkg::*;

   localparam int MASK_MSB = MASK_LSB + SLOTS - 1;

   if (EN_BIT >= CFG_W) begin : g_bad_en
      $error("enable bit outside configuration word");
   end
   if (MASK_MSB >= CFG_W || OFS_W > MASK_LSB) begin : g_bad_fields
      $error("index register fields overlap or exceed the word");
   end

   // only the fields that are decoded are kept as flops
   always_ff @(posedge clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         ofs_q  <= '0;
         mask_q <= '0;
      end else if (wr_en) begin
         if (cfg_sel_e'(wr_sel) == CFG_MODE) begin
            en_q <= wr_data[EN_BIT];
         end else begin
            ofs_q  <= wr_data[OFS_W-1:0];
            mask_q <= wr_data[MASK_MSB:MASK_LSB];
         end
      end
   end

endmodule

// File: rtl/remap_slot.sv
module remap_slot #(
   parameter int OPND_W = 9,
   parameter int OFS_W  = 8
) (
   input  logic [OPND_W-1:0] opnd,
   input  logic              apply,
   input  logic [OFS_W-1:0]  ofs,
   input  logic [OPND_W-1:0] vcount,
   output logic [OPND_W-1:0] res
);
   localparam int NUM_W = OPND_W - 1;
   localparam logic [OPND_W-1:0] VREG_ZERO = {1'b1, {NUM_W{1'b0}}};

   if (OFS_W > NUM_W) begin : g_bad_ofs
      $error("offset wider than register number");
   end

   logic              is_vreg;
   logic [OPND_W-1:0] sum;
   logic              in_range;

   assign is_vreg  = opnd[OPND_W-1];
   // sum kept one bit wider than the register number so it never wraps
   assign sum      = {1'b0, opnd[NUM_W-1:0]} + OPND_W'(ofs);
   assign in_range = sum < vcount;

   always_comb begin
      if (!apply)
         res = opnd;
      else if (!is_vreg || !in_range)
         res = VREG_ZERO;
      else
         res = {1'b1, sum[NUM_W-1:0]};
   end

endmodule

// File: rtl/vreg_offset_remap.sv
module vreg_offset_remap #(
   parameter int OPND_W   = 9,
   parameter int CFG_W    = 32,
   parameter int EN_BIT   = 27,
   parameter int OFS_W    = 8,
   parameter int MASK_LSB = 12
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic              cfg_sel,
   input  logic [CFG_W-1:0]  cfg_wdata,
   input  logic              in_valid,
   input  logic [OPND_W-1:0] in_src0,
   input  logic [OPND_W-1:0] in_src1,
   input  logic [OPND_W-1:0] in_src2,
   input  logic [OPND_W-1:0] in_dst,
   input  logic [OPND_W-1:0] in_vcount,
   output logic              out_valid,
   output logic [OPND_W-1:0] out_src0,
   output logic [OPND_W-1:0] out_src1,
   output logic [OPND_W-1:0] out_src2,
   output logic [OPND_W-1:0] out_dst
);
   import vreg_remap_pkg::*;

   localparam int SLOTS = NUM_SLOTS;

   if (OPND_W < 2) begin : g_bad_opnd
      $error("operand field too narrow");
   end

   logic             cfg_en;
   logic [OFS_W-1:0] cfg_ofs;
   logic [SLOTS-1:0] cfg_mask;

   remap_cfg_regs #(
      .CFG_W   (CFG_W),
      .EN_BIT  (EN_BIT),
      .OFS_W   (OFS_W),
      .MASK_LSB(MASK_LSB),
      .SLOTS   (SLOTS)
   ) u_cfg (
      .clk    (clk),
      .rst    (rst),
      .wr_en  (cfg_we),
      .wr_sel (cfg_sel),
      .wr_data(cfg_wdata),
      .en_q   (cfg_en),
      .ofs_q  (cfg_ofs),
      .mask_q (cfg_mask)
   );

   logic [OPND_W-1:0] opnd_in [SLOTS];
   logic [OPND_W-1:0] res_d   [SLOTS];
   logic [OPND_W-1:0] res_q   [SLOTS];
   logic              vld_q;

   assign opnd_in[SLOT_SRC0] = in_src0;
   assign opnd_in[SLOT_SRC1] = in_src1;
   assign opnd_in[SLOT_SRC2] = in_src2;
   assign opnd_in[SLOT_DST]  = in_dst;

   for (genvar k = 0; k < SLOTS; k++) begin : g_slot
      remap_slot #(
         .OPND_W(OPND_W),
         .OFS_W (OFS_W)
      ) u_slot (
         .opnd  (opnd_in[k]),
         .apply (cfg_en & cfg_mask[k]),
         .ofs   (cfg_ofs),
         .vcount(in_vcount),
         .res   (res_d[k])
      );

      always_ff @(posedge clk) begin
         res_q[k] <= res_d[k];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) vld_q <= 1'b0;
      else     vld_q <= in_valid;
   end

   assign out_valid = vld_q;
   assign out_src0  = res_q[SLOT_SRC0];
   assign out_src1  = res_q[SLOT_SRC1];
   assign out_src2  = res_q[SLOT_SRC2];
   assign out_dst   = res_q[SLOT_DST];

endmodule

// File: rtl/vreg_offset_remap_chk.sv
module vreg_offset_remap_chk #(
   parameter int OPND_W = 9
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [OPND_W-1:0] in_src0,
   input logic [OPND_W-1:0] in_src1,
   input logic [OPND_W-1:0] in_dst,
   input logic [OPND_W-1:0] in_vcount,
   input logic              cfg_en,
   input logic [3:0]        cfg_mask,
   input logic              out_valid,
   input logic [OPND_W-1:0] out_src0,
   input logic [OPND_W-1:0] out_src1,
   input logic [OPND_W-1:0] out_dst
);
   localparam logic [OPND_W-1:0] VZ = {1'b1, {(OPND_W-1){1'b0}}};

   // R1
   reset_clears_valid_chk: assert property (@(posedge clk)
      rst |=> !out_valid);

   // R2
   valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   // R2
   no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   // R3
   disabled_passthru_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cfg_en) |=> (out_src0 == $past(in_src0)) && (out_dst == $past(in_dst)));

   // R5
   unselected_passthru_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !cfg_mask[1]) |=> out_src1 == $past(in_src1));

   // R7
   nonvec_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cfg_en && cfg_mask[0] && !in_src0[OPND_W-1]) |=> out_src0 == VZ);

   // R6
   dst_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && cfg_en && cfg_mask[3]) |=>
         out_dst[OPND_W-1] && ((out_dst == VZ) ||
         ({1'b0, out_dst[OPND_W-2:0]} < $past(in_vcount))));

endmodule

bind vreg_offset_remap vreg_offset_remap_chk #(.OPND_W(OPND_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .in_valid (in_valid),
   .in_src0  (in_src0),
   .in_src1  (in_src1),
   .in_dst   (in_dst),
   .in_vcount(in_vcount),
   .cfg_en   (cfg_en),
   .cfg_mask (cfg_mask),
   .out_valid(out_valid),
   .out_src0 (out_src0),
   .out_src1 (out_src1),
   .out_dst  (out_dst)
);

// File: tb/test_vreg_offset_remap.sv
module test_vreg_offset_remap;
   localparam int CLK_PERIOD = 10;
   localparam logic [8:0] VZ = 9'd256;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic        cfg_sel = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic        in_valid = 1'b0;
   logic [8:0]  in_src0 = '0, in_src1 = '0, in_src2 = '0, in_dst = '0;
   logic [8:0]  in_vcount = 9'd1;
   logic        out_valid;
   logic [8:0]  out_src0, out_src1, out_src2, out_dst;

   always #(CLK_PERIOD/2) clk = ~clk;

   vreg_offset_remap i_vreg_offset_remap (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .in_valid(in_valid), .in_src0(in_src0), .in_src1(in_src1), .in_src2(in_src2),
      .in_dst(in_dst), .in_vcount(in_vcount), .out_valid(out_valid),
      .out_src0(out_src0), .out_src1(out_src1), .out_src2(out_src2), .out_dst(out_dst)
   );

   typedef struct {
      logic [8:0] e0, e1, e2, e3;
      string      tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done   = 1'b0;

   // bench model of the configuration
   logic       m_en   = 1'b0;
   logic [7:0] m_ofs  = '0;
   logic [3:0] m_mask = '0;

   function automatic logic [8:0] model(logic [8:0] op, logic sel, logic [8:0] cnt);
      logic [8:0] s;
      if (!m_en || !sel) return op;
      if (!op[8]) return VZ;
      s = {1'b0, op[7:0]} + {1'b0, m_ofs};
      if (s >= cnt) return VZ;
      return {1'b1, s[7:0]};
   endfunction

   task automatic check(string tag, string what, logic [8:0] act, logic [8:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push(logic [8:0] s0, s1, s2, d, cnt, string tag);
      exp_t e;
      e.e0 = model(s0, m_mask[0], cnt);
      e.e1 = model(s1, m_mask[1], cnt);
      e.e2 = model(s2, m_mask[2], cnt);
      e.e3 = model(d,  m_mask[3], cnt);
      e.tag = tag;
      q.push_back(e);
      in_valid = 1'b1; in_src0 = s0; in_src1 = s1; in_src2 = s2; in_dst = d;
      in_vcount = cnt;
   endtask

   task automatic model_write(logic sel, logic [31:0] data);
      if (!sel) m_en = data[27];
      else begin m_ofs = data[7:0]; m_mask = data[15:12]; end
   endtask

   task automatic send(logic [8:0] s0, s1, s2, d, cnt, string tag);
      @(negedge clk);
      cfg_we = 1'b0;
      push(s0, s1, s2, d, cnt, tag);
   endtask

   task automatic wr(logic sel, logic [31:0] data);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      model_write(sel, data);
   endtask

   // write and instruction on the same cycle: instruction sees old values
   task automatic send_wr(logic sel, logic [31:0] data,
                          logic [8:0] s0, s1, s2, d, cnt, string tag);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
      push(s0, s1, s2, d, cnt, tag);
      model_write(sel, data);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cfg_we = 1'b0; in_valid = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; cfg_we = 1'b0; in_valid = 1'b0;
      m_en = 1'b0; m_ofs = '0; m_mask = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
   endtask

   // monitor: pops the scoreboard whenever a result appears
   always @(negedge clk) begin
      if (!rst && out_valid) begin
         if (q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R2 unexpected out_valid: actual 1 expected 0");
         end else begin
            exp_t e;
            e = q.pop_front();
            check(e.tag, "src0", out_src0, e.e0);
            check(e.tag, "src1", out_src1, e.e1);
            check(e.tag, "src2", out_src2, e.e2);
            check(e.tag, "dst",  out_dst,  e.e3);
         end
      end
   end

   task automatic finish_run();
      idle(3);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R2 results missing: actual %0d expected 0", q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1 reset state
      @(negedge clk);
      check("R1", "out_valid after reset", {8'd0, out_valid}, 9'd0);
      // R1: cleared config -> pass through
      send(9'd300, 9'd5, 9'd511, 9'd256, 9'd10, "R1");
      idle(1);
      // R2: idle cycle gives no valid
      @(negedge clk);
      check("R2", "out_valid idle", {8'd0, out_valid}, 9'd0);
      // R3: mask and offset loaded, enable clear -> pass-through
      wr(1'b1, 32'h0000_F005);
      send(9'd266, 9'd3, 9'd400, 9'd270, 9'd100, "R3");
      // R5: enable on, mask empty
      wr(1'b0, 32'h0800_0000);
      wr(1'b1, 32'h0000_0005);
      send(9'd266, 9'd3, 9'd400, 9'd270, 9'd100, "R5");
      // R4/R5: only src0 selected
      wr(1'b1, 32'h0000_1005);
      send(9'd266, 9'd267, 9'd268, 9'd269, 9'd100, "R4");
      // R5: only dst selected
      wr(1'b1, 32'h0000_8005);
      send(9'd266, 9'd267, 9'd268, 9'd269, 9'd100, "R5");
      // R6/R7: all selected, mixed slots, back to back
      wr(1'b1, 32'h0000_F005);
      send(9'd350, 9'd5, 9'd351, 9'd456, 9'd100, "R6");
      send(9'd100, 9'd256, 9'd0, 9'd255, 9'd100, "R7");
      // R6: full count, largest sum must not wrap
      wr(1'b1, 32'h0000_F0FF);
      send(9'd511, 9'd256, 9'd257, 9'd300, 9'd256, "R6");
      // R6: count of one
      wr(1'b1, 32'h0000_F000);
      send(9'd256, 9'd257, 9'd256, 9'd260, 9'd1, "R6");
      // R8: write on same cycle as instruction, then new value next cycle
      wr(1'b1, 32'h0000_F001);
      send_wr(1'b1, 32'h0000_3010, 9'd260, 9'd260, 9'd260, 9'd260, 9'd200, "R8");
      send(9'd260, 9'd260, 9'd260, 9'd260, 9'd200, "R8");
      send_wr(1'b0, 32'h0000_0000, 9'd270, 9'd270, 9'd270, 9'd270, 9'd200, "R8");
      send(9'd270, 9'd270, 9'd270, 9'd270, 9'd200, "R8");
      // R3: mode write with other bits but bit 27 clear keeps indexing off
      wr(1'b0, 32'hF7FF_FFFF);
      send(9'd270, 9'd1, 9'd270, 9'd270, 9'd200, "R3");
      wr(1'b0, 32'h0800_0000);
      send(9'd270, 9'd1, 9'd270, 9'd270, 9'd200, "R4");
      idle(3);
      // R1: reset mid-run clears config
      do_reset();
      @(negedge clk);
      check("R1", "out_valid after second reset", {8'd0, out_valid}, 9'd0);
      send(9'd270, 9'd1, 9'd270, 9'd270, 9'd200, "R1");
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL WDOG run did not complete: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule